// File: doc/BRIEF.md
# Halfword Byte-Swap DMA Bridge

This bridge connects the DMA port of a 16-bit network controller to the system memory bus. The controller presents a request with a device address, a byte count, a direction and a swap flag. The bridge ORs a base value into the device address to form the memory address. It then issues one or more burst commands on the memory side and carries the 16-bit data beats between the two sides with valid/ready handshakes.

When the swap flag is set, the bridge reverses the two bytes of every halfword in both directions. It also clears bit 0 of the address and of the length so that a transfer never covers half a halfword. Swapped writes are split into bursts of at most `BURST_BYTES` bytes. Without the swap flag, the address and length pass through unchanged and each request issues a single command. The bridge accepts a new request only while it is idle. When the last beat has moved, it signals completion with a one-cycle pulse.

Top module: `hwswap_dma`

## Requirements
- R1: The first memory command address equals `req_addr | base_addr`, a bitwise OR and not a sum, with bit 0 then cleared when swapping.
- R2: In swap mode, bit 0 of the command address and bit 0 of the command length are zero. The length is the request length with bit 0 cleared.
- R3: In swap mode, write data to memory is the device halfword with its bytes exchanged: `mem_wdata[15:8] = dev_wdata[7:0]` and `mem_wdata[7:0] = dev_wdata[15:8]`.
- R4: In swap mode, read data to the device is the memory halfword with its bytes exchanged, in the same way.
- R5: A swapped write is issued as consecutive commands of `min(remaining, BURST_BYTES)` bytes (default 64). Each command's address is the previous one plus the previous length. Swapped reads issue one command. A command holds its address and length until `mem_cmd_ready`.
- R6: Without swap, the address is `req_addr | base_addr` unchanged and the length is unchanged, odd values included. A single command is issued and data passes with no byte change.
- R7: `done` is high for exactly one cycle, on the cycle after the clock edge that completes the final beat. It stays low at the end of non-final bursts.
- R8: A request whose effective length is zero pulses `done` on the cycle after acceptance and issues no memory command. A swapped request of length 1 counts as zero length.
- R9: `req_ready` is high only while idle. A request presented while busy is ignored: it neither alters the command in progress nor starts a transfer afterwards.
- R10: After reset, `req_ready` is 1, `done` is 0 and `mem_cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_addr | input | AW | Base value ORed into the device address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request taken |
| req_write | input | 1 | 1 = device to memory, 0 = memory to device |
| req_swap | input | 1 | Enable halfword byte swap and alignment |
| req_addr | input | AW | Device byte address |
| req_len | input | LW | Byte count |
| done | output | 1 | One-cycle completion pulse |
| dev_wvalid | input | 1 | Device write beat valid |
| dev_wready | output | 1 | Device write beat taken |
| dev_wdata | input | 16 | Device write halfword |
| dev_rvalid | output | 1 | Read beat to device valid |
| dev_rready | input | 1 | Device takes read beat |
| dev_rdata | output | 16 | Read halfword to device |
| mem_cmd_valid | output | 1 | Burst command valid |
| mem_cmd_ready | input | 1 | Burst command taken |
| mem_cmd_write | output | 1 | Burst direction |
| mem_cmd_addr | output | AW | Burst byte address |
| mem_cmd_len | output | LW | Burst byte count |
| mem_wvalid | output | 1 | Memory write beat valid |
| mem_wready | input | 1 | Memory takes write beat |
| mem_wdata | output | 16 | Memory write halfword |
| mem_rvalid | input | 1 | Memory read beat valid |
| mem_rready | output | 1 | Read beat taken |
| mem_rdata | input | 16 | Memory read halfword |

## Verification
A memory command appears on the cycle after the request is accepted, and on the cycle after the last beat of a non-final burst. Data beats are combinational, so swapped or passed-through data is due in the same cycle as the handshake. `done` rises on the cycle after the final beat edge, or on the cycle after acceptance for a zero-length request. The bench drives inputs on the falling edge and checks data a short delay later within the same cycle. It checks registered outputs on the falling edge after the edge that updates them, counting a one-cycle step for every stage.

// File: rtl/hwswap_dma.sv
module hwswap_dma #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int BURST_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_swap,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          done,
  input  logic          dev_wvalid,
  output logic          dev_wready,
  input  logic [15:0]   dev_wdata,
  output logic          dev_rvalid,
  input  logic          dev_rready,
  output logic [15:0]   dev_rdata,
  output logic          mem_cmd_valid,
  input  logic          mem_cmd_ready,
  output logic          mem_cmd_write,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [LW-1:0] mem_cmd_len,
  output logic          mem_wvalid,
  input  logic          mem_wready,
  output logic [15:0]   mem_wdata,
  input  logic          mem_rvalid,
  output logic          mem_rready,
  input  logic [15:0]   mem_rdata
);
  localparam logic [LW-1:0] BURST = LW'(BURST_BYTES);
  localparam logic [LW-1:0] BEAT  = LW'(2);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DATA} st_t;

  st_t           state;
  logic          write_q, swap_q, done_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q, chunk_q, left_q;

  function automatic logic [LW-1:0] chunk_of(input logic [LW-1:0] n, input logic split);
    return (split && n > BURST) ? BURST : n;
  endfunction

  function automatic logic [15:0] xchg(input logic [15:0] d, input logic en);
    return en ? {d[7:0], d[15:8]} : d;
  endfunction

  wire [AW-1:0] raw_addr   = req_addr | base_addr;
  wire [AW-1:0] start_addr = req_swap ? {raw_addr[AW-1:1], 1'b0} : raw_addr;
  wire [LW-1:0] start_len  = req_swap ? {req_len[LW-1:1], 1'b0} : req_len;
  wire          accept     = req_valid && state == S_IDLE;
  wire          in_data    = state == S_DATA;

  assign req_ready     = state == S_IDLE;
  assign done          = done_q;
  assign mem_cmd_valid = state == S_CMD;
  assign mem_cmd_write = write_q;
  assign mem_cmd_addr  = addr_q;
  assign mem_cmd_len   = chunk_q;

  assign mem_wvalid = in_data && write_q && dev_wvalid;
  assign dev_wready = in_data && write_q && mem_wready;
  assign mem_wdata  = xchg(dev_wdata, swap_q);
  assign dev_rvalid = in_data && !write_q && mem_rvalid;
  assign mem_rready = in_data && !write_q && dev_rready;
  assign dev_rdata  = xchg(mem_rdata, swap_q);

  wire          beat      = in_data && (write_q ? (dev_wvalid && mem_wready) : (mem_rvalid && dev_rready));
  wire          chunk_end = beat && left_q <= BEAT;
  wire          xfer_end  = chunk_end && rem_q == chunk_q;
  wire [LW-1:0] rem_next  = rem_q - chunk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done_q  <= 1'b0;
      write_q <= 1'b0;
      swap_q  <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      left_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          write_q <= req_write;
          swap_q  <= req_swap;
          addr_q  <= start_addr;
          rem_q   <= start_len;
          chunk_q <= chunk_of(start_len, req_swap && req_write);
          if (start_len == '0) done_q <= 1'b1;
          else                 state  <= S_CMD;
        end
        S_CMD: if (mem_cmd_ready) begin
          left_q <= chunk_q;
          state  <= S_DATA;
        end
        S_DATA: if (beat) begin
          left_q <= (left_q >= BEAT) ? left_q - BEAT : '0;
          if (xfer_end) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else if (chunk_end) begin
            addr_q  <= addr_q + AW'(chunk_q);
            rem_q   <= rem_next;
            chunk_q <= chunk_of(rem_next, swap_q && write_q);
            state   <= S_CMD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hwswap_dma_chk.sv
module hwswap_dma_chk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int BURST_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_ready,
  input logic [AW-1:0] mem_cmd_addr,
  input logic [LW-1:0] mem_cmd_len,
  input logic          swap_q,
  input logic          write_q,
  input logic          mem_wvalid,
  input logic [15:0]   mem_wdata,
  input logic [15:0]   dev_wdata
);
  // R2
  cmd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && swap_q |-> !mem_cmd_addr[0] && !mem_cmd_len[0]);

  // R5
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && swap_q && write_q |-> mem_cmd_len <= LW'(BURST_BYTES));

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len));

  // R3
  wr_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && swap_q |-> mem_wdata[7:0] == dev_wdata[15:8] && mem_wdata[15:8] == dev_wdata[7:0]);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  cmd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> mem_cmd_len != '0);

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> !req_ready);
endmodule

bind hwswap_dma hwswap_dma_chk #(.AW(AW), .LW(LW), .BURST_BYTES(BURST_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_addr(mem_cmd_addr), .mem_cmd_len(mem_cmd_len),
  .swap_q(swap_q), .write_q(write_q),
  .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .dev_wdata(dev_wdata)
);

// File: tb/hwswap_dma_tb.sv
module hwswap_dma_tb;
  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] base_addr = '0, req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_valid = 0, req_write = 0, req_swap = 0;
  logic req_ready, done;
  logic dev_wvalid = 0, dev_rready = 0, mem_cmd_ready = 0, mem_wready = 0, mem_rvalid = 0;
  logic [15:0] dev_wdata = '0, mem_rdata = '0;
  logic dev_wready, dev_rvalid, mem_cmd_valid, mem_cmd_write, mem_wvalid, mem_rready;
  logic [15:0] dev_rdata, mem_wdata;
  logic [AW-1:0] mem_cmd_addr;
  logic [LW-1:0] mem_cmd_len;

  int checks = 0, fails = 0, beat_no = 0;

  always #2 clk = ~clk;

  hwswap_dma #(.AW(AW), .LW(LW), .BURST_BYTES(64)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {write, swap, stall, base[31:0], addr[31:0], len[15:0]}
  localparam logic [82:0] VEC [10] = '{
    {1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_0021, 16'd7},
    {1'b1, 1'b1, 1'b1, 32'h0000_2000, 32'h0000_0004, 16'd150},
    {1'b0, 1'b1, 1'b0, 32'h0000_0100, 32'h0000_0033, 16'd9},
    {1'b1, 1'b0, 1'b1, 32'h0000_0430, 32'h0000_0011, 16'd5},
    {1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0055, 16'd3},
    {1'b1, 1'b1, 1'b0, 32'h0000_0200, 32'h0000_0008, 16'd1},
    {1'b0, 1'b0, 1'b0, 32'h0000_0200, 32'h0000_0008, 16'd0},
    {1'b1, 1'b1, 1'b0, 32'h0000_3000, 32'h0000_0000, 16'd128},
    {1'b0, 1'b1, 1'b1, 32'h0000_0800, 32'h0000_0003, 16'd100},
    {1'b1, 1'b0, 1'b0, 32'h0000_0F00, 32'h0000_0F0F, 16'd130}
  };

  task automatic run_xfer(input logic w, input logic s, input logic stall,
                          input logic [AW-1:0] base, input logic [AW-1:0] addr, input logic [LW-1:0] len);
    logic [AW-1:0] a;
    int rem, ch;
    a   = addr | base;
    rem = int'(len);
    if (s) begin
      a[0] = 1'b0;
      rem  = rem & ~1;
    end
    check(req_ready === 1'b1, "R9 idle ready", 64'(req_ready), 64'd1);
    base_addr = base; req_addr = addr; req_len = len; req_write = w; req_swap = s; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (rem == 0) begin
      check(done === 1'b1, "R8 zero-length done", 64'(done), 64'd1);
      check(mem_cmd_valid === 1'b0, "R8 no command", 64'(mem_cmd_valid), 64'd0);
      @(negedge clk);
      check(done === 1'b0, "R7 done one cycle", 64'(done), 64'd0);
      return;
    end
    while (rem > 0) begin
      ch = (s && w && rem > 64) ? 64 : rem;
      check(done === 1'b0, "R7 no early done", 64'(done), 64'd0);
      check(mem_cmd_valid === 1'b1, "R5 command present", 64'(mem_cmd_valid), 64'd1);
      check(mem_cmd_addr === a, s ? "R2 command address" : "R1 command address", 64'(mem_cmd_addr), 64'(a));
      check(mem_cmd_len === LW'(ch), s ? "R5 command length" : "R6 command length", 64'(mem_cmd_len), 64'(ch));
      check(mem_cmd_write === w, "R6 command direction", 64'(mem_cmd_write), 64'(w));
      if (stall) begin
        @(negedge clk);
        check(mem_cmd_valid === 1'b1 && mem_cmd_addr === a, "R5 command held", 64'(mem_cmd_addr), 64'(a));
      end
      mem_cmd_ready = 1;
      @(negedge clk);
      mem_cmd_ready = 0;
      for (int i = 0; i < (ch + 1) / 2; i++) begin
        logic [15:0] d, e;
        d = {8'(beat_no * 2 + 8'h31), 8'(beat_no * 3 + 8'h07)};
        e = s ? {d[7:0], d[15:8]} : d;
        beat_no++;
        if (w) begin
          dev_wdata = d; dev_wvalid = 1; mem_wready = 1;
          #1;
          check(mem_wvalid === 1'b1 && mem_wdata === e, s ? "R3 write swap" : "R6 write pass",
                64'(mem_wdata), 64'(e));
        end else begin
          mem_rdata = d; mem_rvalid = 1; dev_rready = 1;
          #1;
          check(dev_rvalid === 1'b1 && dev_rdata === e, s ? "R4 read swap" : "R6 read pass",
                64'(dev_rdata), 64'(e));
        end
        @(negedge clk);
      end
      dev_wvalid = 0; mem_wready = 0; mem_rvalid = 0; dev_rready = 0;
      rem -= ch;
      a   += AW'(ch);
    end
    check(done === 1'b1, "R7 done after last beat", 64'(done), 64'd1);
    @(negedge clk);
    check(done === 1'b0, "R7 done one cycle", 64'(done), 64'd0);
    check(req_ready === 1'b1, "R9 idle again", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready === 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);
    check(done === 1'b0, "R10 reset done", 64'(done), 64'd0);
    check(mem_cmd_valid === 1'b0, "R10 reset command", 64'(mem_cmd_valid), 64'd0);

    for (int v = 0; v < 10; v++)
      run_xfer(VEC[v][82], VEC[v][81], VEC[v][80], VEC[v][79:48], VEC[v][47:16], VEC[v][15:0]);

    // R9: request while busy is ignored
    base_addr = '0; req_addr = 32'h10; req_len = 16'd2; req_write = 1; req_swap = 0; req_valid = 1;
    @(negedge clk);
    req_addr = 32'h300; req_len = 16'd40; req_write = 0; req_swap = 1;
    check(req_ready === 1'b0, "R9 busy not ready", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_valid = 0;
    check(mem_cmd_addr === 32'h10 && mem_cmd_len === 16'd2, "R9 busy command kept",
          64'(mem_cmd_addr), 64'h10);
    mem_cmd_ready = 1;
    @(negedge clk);
    mem_cmd_ready = 0; dev_wdata = 16'h1234; dev_wvalid = 1; mem_wready = 1;
    @(negedge clk);
    dev_wvalid = 0; mem_wready = 0;
    check(done === 1'b1, "R7 done after busy test", 64'(done), 64'd1);
    @(negedge clk);
    @(negedge clk);
    check(mem_cmd_valid === 1'b0 && req_ready === 1'b1, "R9 ignored request not started",
          64'(mem_cmd_valid), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule